// File: doc/BRIEF.md
# Retired-Instruction Countdown Trigger

This block is one debug trigger that counts retired instructions down and asks for a breakpoint when the count runs out. Its control word holds a 14-bit remaining count and five privilege enables. Each retire pulse that arrives while the hart runs in an enabled privilege mode takes one off the count. When the count goes from one to zero, the block raises a breakpoint request for exactly one cycle. A count of zero leaves the trigger idle.

The control word is written by the CSR path through a single write strobe. A read of the control word returns the count as it stands now, so software can see how many instructions remain. A write overrides any retire in the same cycle. The only fields the control word keeps are the mode enables and the count. The type code always reads as 3, and every other bit reads as zero.

Top module: `icount_trigger`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets. After that edge cfg_rdata reads 0x3000_0000 (type code 3 in bits [31:28], everything else zero) and fire is 0.
- R2: A write with cfg_wr keeps only the count (bits [23:10]) and the enables U (bit 6), S (bit 7), M (bit 9), VU (bit 25) and VS (bit 26). Every other bit reads back as zero, except bits [31:28], which always read as 3. Writing all ones reads back 0x36FF_FEC0.
- R3: When virt is 0, a retire decrements the count by one if the enable for priv is set. The enable for priv 0 is bit 6, for priv 1 bit 7 and for priv 3 bit 9.
- R4: When virt is 1, a retire decrements the count if the enable for priv is set: bit 25 for priv 0 and bit 26 for priv 1. The U, S and M enables have no effect while virt is 1, and neither does priv 3.
- R5: A retire in a privilege mode whose enable is clear leaves the count unchanged. Privilege 2 never counts.
- R6: A decrement from 1 to 0 sets fire high for exactly one cycle, in the same cycle that the count first reads 0.
- R7: A count of zero never wraps and never fires, whatever the retire and privilege inputs are.
- R8: A write loads the written count after the next edge. A retire in the same cycle as the write is dropped and cannot fire.
- R9: With neither a write nor a retire, the count holds and fire stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | XLEN | Control word write data |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt | input | 1 | Hart runs virtualized |
| cfg_rdata | output | XLEN | Control word with live count |
| fire | output | 1 | One-cycle breakpoint request |

## Verification
The bench builds the block with its default parameters: XLEN 32, a 14-bit count at bit 10. With a 14-bit count, a full countdown from 16383 is short enough to run completely. That run shows that fire comes only on the final step and never early. The default layout also places every enable bit and the count field at a fixed position that the bench can decode, so masking on write is checked against exact read-back words.

// File: rtl/icount_pkg.sv
// Package: field positions and codes shared by the countdown trigger.
// Assumes a control word of at least 32 bits with the type code in its top nibble.
package icount_pkg;

    localparam int unsigned BIT_U  = 6;
    localparam int unsigned BIT_S  = 7;
    localparam int unsigned BIT_M  = 9;
    localparam int unsigned BIT_VU = 25;
    localparam int unsigned BIT_VS = 26;

    localparam logic [3:0] TYPE_CODE = 4'd3;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // Per-mode enables held by the trigger.
    typedef struct packed {
        logic vs;
        logic vu;
        logic m;
        logic s;
        logic u;
    } mode_en_t;

endpackage

// File: rtl/icount_mode_qual.sv
// Module: decides whether the current privilege/virtualization state is one
// in which retired instructions count. Purely combinational.
// Assumes priv 2 is reserved, and that a virtualized hart runs only at priv 0 or 1.
module icount_mode_qual
    import icount_pkg::*;
(
    input  mode_en_t   mode_en,
    input  logic [1:0] priv,
    input  logic       virt,
    output logic       qualify
);

    // Pick the enable bit that belongs to the current mode.
    always_comb begin
        qualify = 1'b0;
        if (virt) begin
            case (priv)
                PRIV_U:  qualify = mode_en.vu;
                PRIV_S:  qualify = mode_en.vs;
                default: qualify = 1'b0;
            endcase
        end else begin
            case (priv)
                PRIV_U:  qualify = mode_en.u;
                PRIV_S:  qualify = mode_en.s;
                PRIV_M:  qualify = mode_en.m;
                default: qualify = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/icount_counter.sv
// Module: holds the remaining count. It loads on a write, steps down on a
// qualified retire, and pulses fire on the step from one to zero.
// Assumes a load and a step never both take effect: the load wins.
module icount_counter #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic live;
    assign live = (cnt != CNT_ZERO);

    // Count register and its single-cycle zero-crossing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= CNT_ZERO;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (step && live) begin
                cnt  <= cnt - CNT_ONE;
                fire <= (cnt == CNT_ONE);
            end
        end
    end

endmodule

// File: rtl/icount_cfg.sv
// Module: keeps the mode enables from a control word write and builds the
// read-back word from those enables, the fixed type code and the live count.
// Assumes that the count field overlaps none of the enable bits or the type nibble.
module icount_cfg
    import icount_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CNT_LSB = 10,
    parameter int unsigned CNT_W   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [XLEN-1:0]  wdata,
    input  logic [CNT_W-1:0] cnt,
    output mode_en_t         mode_en,
    output logic [CNT_W-1:0] wr_cnt,
    output logic [XLEN-1:0]  rdata
);

    localparam int unsigned TYPE_MSB = XLEN - 1;

    assign wr_cnt = wdata[CNT_LSB +: CNT_W];

    // Keep only the enable bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en <= '0;
        end else if (wr) begin
            mode_en.u  <= wdata[BIT_U];
            mode_en.s  <= wdata[BIT_S];
            mode_en.m  <= wdata[BIT_M];
            mode_en.vu <= wdata[BIT_VU];
            mode_en.vs <= wdata[BIT_VS];
        end
    end

    // Build the read-back word; unkept fields stay zero.
    always_comb begin
        rdata                       = '0;
        rdata[TYPE_MSB -: 4]        = TYPE_CODE;
        rdata[BIT_U]                = mode_en.u;
        rdata[BIT_S]                = mode_en.s;
        rdata[BIT_M]                = mode_en.m;
        rdata[BIT_VU]               = mode_en.vu;
        rdata[BIT_VS]               = mode_en.vs;
        rdata[CNT_LSB +: CNT_W]     = cnt;
    end

endmodule

// File: rtl/icount_trigger.sv
// Module: top of the retired-instruction countdown trigger. It connects the
// configuration store, the mode qualifier and the count register.
// Assumes at most one retired instruction per cycle.
module icount_trigger
    import icount_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CNT_LSB = 10,
    parameter int unsigned CNT_W   = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [XLEN-1:0] cfg_wdata,
    input  logic            retire,
    input  logic [1:0]      priv,
    input  logic            virt,
    output logic [XLEN-1:0] cfg_rdata,
    output logic            fire
);

    mode_en_t         mode_en;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wr_cnt;
    logic             qualify;
    logic             step;

    icount_cfg #(
        .XLEN    (XLEN),
        .CNT_LSB (CNT_LSB),
        .CNT_W   (CNT_W)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .cnt     (cnt),
        .mode_en (mode_en),
        .wr_cnt  (wr_cnt),
        .rdata   (cfg_rdata)
    );

    icount_mode_qual i_qual (
        .mode_en (mode_en),
        .priv    (priv),
        .virt    (virt),
        .qualify (qualify)
    );

    // A retire counts only in an enabled mode.
    assign step = retire && qualify;

    icount_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_val (wr_cnt),
        .step     (step),
        .cnt      (cnt),
        .fire     (fire)
    );

endmodule

// File: rtl/icount_trigger_chk.sv
// Checker: port-level properties of the countdown trigger, bound to the top.
module icount_trigger_chk #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CNT_LSB = 10,
    parameter int unsigned CNT_W   = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr,
    input logic [XLEN-1:0] cfg_wdata,
    input logic            retire,
    input logic [1:0]      priv,
    input logic            virt,
    input logic [XLEN-1:0] cfg_rdata,
    input logic            fire
);

    logic [CNT_W-1:0] cnt;
    assign cnt = cfg_rdata[CNT_LSB +: CNT_W];

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!fire && cnt == '0));

    p_fire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    p_fire_from_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !cfg_wr && cnt == CNT_W'(1)) |=> (fire || cnt == CNT_W'(1)));

    p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !cfg_wr) |=> (cnt == '0 && !fire));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cnt == $past(cfg_wdata[CNT_LSB +: CNT_W]) && !fire));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !retire) |=> ($stable(cnt) && !fire));

    p_reserved_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && priv == 2'd2) |=> $stable(cnt));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

endmodule

bind icount_trigger icount_trigger_chk #(
    .XLEN    (XLEN),
    .CNT_LSB (CNT_LSB),
    .CNT_W   (CNT_W)
) i_chk (.*);

// File: tb/test_icount_trigger.sv
module test_icount_trigger;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic        retire;
    logic [1:0]  priv;
    logic        virt;
    logic [31:0] cfg_rdata;
    logic        fire;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    icount_trigger i_icount_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .retire    (retire),
        .priv      (priv),
        .virt      (virt),
        .cfg_rdata (cfg_rdata),
        .fire      (fire)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wd;
        logic        ret;
        logic [1:0]  pv;
        logic        vt;
        logic [13:0] cnt;
        logic        fr;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'hF100_0F3F, 1'b0, 2'd0, 1'b0, 14'd3, 1'b0}, // R2 load 3, M only
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd2, 1'b0}, // R3 M counts
        '{1'b0, 32'h0,         1'b1, 2'd0, 1'b0, 14'd2, 1'b0}, // R5 U off
        '{1'b0, 32'h0,         1'b1, 2'd1, 1'b0, 14'd2, 1'b0}, // R5 S off
        '{1'b0, 32'h0,         1'b1, 2'd2, 1'b0, 14'd2, 1'b0}, // R5 priv 2
        '{1'b0, 32'h0,         1'b0, 2'd3, 1'b0, 14'd2, 1'b0}, // R9 idle
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd1, 1'b0}, // R3
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd0, 1'b1}, // R6 fire
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd0, 1'b0}, // R7 stays zero
        '{1'b1, 32'h0000_14C0, 1'b1, 2'd0, 1'b0, 14'd5, 1'b0}, // R8 write wins
        '{1'b0, 32'h0,         1'b1, 2'd0, 1'b0, 14'd4, 1'b0}, // R3 U
        '{1'b0, 32'h0,         1'b1, 2'd1, 1'b0, 14'd3, 1'b0}, // R3 S
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd3, 1'b0}, // R5 M off
        '{1'b0, 32'h0,         1'b1, 2'd0, 1'b1, 14'd3, 1'b0}, // R4 U ignored when virt
        '{1'b1, 32'h0600_0A00, 1'b0, 2'd0, 1'b0, 14'd2, 1'b0}, // R2 VU VS M
        '{1'b0, 32'h0,         1'b1, 2'd0, 1'b1, 14'd1, 1'b0}, // R4 VU
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b1, 14'd1, 1'b0}, // R4 priv 3 when virt
        '{1'b0, 32'h0,         1'b1, 2'd1, 1'b1, 14'd0, 1'b1}, // R4 R6 VS fire
        '{1'b1, 32'h0000_0600, 1'b1, 2'd3, 1'b0, 14'd1, 1'b0}, // R8 load 1, no fire
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd0, 1'b1}, // R6
        '{1'b1, 32'h0000_0200, 1'b0, 2'd3, 1'b0, 14'd0, 1'b0}, // R7 load zero
        '{1'b0, 32'h0,         1'b1, 2'd3, 1'b0, 14'd0, 1'b0}  // R7 no fire
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [31:0] d, input logic r,
                         input logic [1:0] p, input logic v);
        cfg_wr = w; cfg_wdata = d; retire = r; priv = p; virt = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 32'h0, 1'b0, 2'd3, 1'b0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata", cfg_rdata, 32'h3000_0000);
        chk("R1 fire", {31'd0, fire}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: junk bits dropped
        drive(1'b1, 32'hF100_0F3F, 1'b0, 2'd3, 1'b0);
        @(negedge clk);
        chk("R2 junk write", cfg_rdata, 32'h3000_0E00);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].wd, VEC[i].ret, VEC[i].pv, VEC[i].vt);
            @(negedge clk);
            chk($sformatf("vec %0d cnt", i), {18'd0, cfg_rdata[23:10]}, {18'd0, VEC[i].cnt});
            chk($sformatf("vec %0d fire", i), {31'd0, fire}, {31'd0, VEC[i].fr});
        end

        // R2: all ones write
        drive(1'b1, 32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0);
        @(negedge clk);
        chk("R2 all ones", cfg_rdata, 32'h36FF_FEC0);

        // R3 R6: full countdown from the largest count
        begin
            int early = 0;
            drive(1'b0, 32'h0, 1'b1, 2'd3, 1'b0);
            for (int k = 0; k < 16382; k++) begin
                @(negedge clk);
                if (fire) early++;
            end
            chk("R6 no early fire", early, 0);
            chk("R3 count at one", {18'd0, cfg_rdata[23:10]}, 32'd1);
            @(negedge clk);
            chk("R6 final fire", {31'd0, fire}, 32'd1);
            chk("R6 final count", {18'd0, cfg_rdata[23:10]}, 32'd0);
            drive(1'b0, 32'h0, 1'b0, 2'd3, 1'b0);
            @(negedge clk);
            chk("R6 pulse ends", {31'd0, fire}, 32'd0);
        end

        // R1: reset in mid-count
        drive(1'b1, 32'h0000_1600, 1'b0, 2'd3, 1'b0);
        @(negedge clk);
        drive(1'b0, 32'h0, 1'b1, 2'd3, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset", cfg_rdata, 32'h3000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", cfg_rdata, 32'h3000_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule